// File: doc/BRIEF.md
# HDLC Receive Block Buffer with Programmable Threshold

This block sits between an HDLC deframer and a host. The deframer writes received bytes one at a time, and flags the last byte of each frame. The bytes go into a 64-byte circular store. They are cut into blocks whose size is chosen by a 2-bit threshold code. When a block is complete, it is presented to the host and a one-cycle interrupt pulse is raised. The pulse is a pool-full interrupt when the block reached the threshold size, and a message-end interrupt when a frame ended inside it. The presented block's byte count is shown on an output.

The host reads the presented block byte by byte through a simple read port. It then issues a message-complete command, and that command frees the space. While one block is presented, further bytes collect into the next block. That next block can complete and wait, and it is handed over on the same clock edge as the message-complete command. A new threshold code written by the host is held in a shadow register. It takes effect only while reception is idle, or once the presented block has been fully read and not yet freed.

The asynchronous reset is released through a two-flop synchronizer. The block therefore leaves reset two clock edges after `rst_n` rises.

Top module: `rx_block_buffer`

## Requirements
- R1: After reset, `blk_count` is 0, `irq_full`, `irq_end` and `overflow` are 0, and threshold code 00 (32 bytes) is in force.
- R2: Threshold codes map to block sizes as follows: 00 gives 32 bytes, 01 gives 16, 10 gives 4 and 11 gives 2. When the byte that brings an unpresented block to that size is written, `irq_full` pulses for one cycle after that clock edge, and `blk_count` shows the size.
- R3: A byte written with `wr_eof` high closes its block. `irq_end` then pulses for one cycle, and `blk_count` equals the number of bytes up to and including that byte. When that byte also reaches the size, only `irq_end` pulses.
- R4: `rd_data` shows the next unread byte of the presented block, in write order, and each `rd_en` cycle advances to the following byte. An `rd_en` issued after the whole block has been read, or with no block presented, has no effect.
- R5: `msg_done` frees the presented block, and `blk_count` returns to 0 unless a waiting block is presented on the same edge. A `msg_done` with no block presented is ignored, and bytes already held stay in place.
- R6: A threshold written with `thr_load` takes effect only when no bytes are held, or when the presented block has been fully read and `msg_done` has not yet been issued. Until then, blocks close at the old size.
- R7: While a block is presented, incoming bytes form the next block. When that block completes, it waits without an interrupt. It is presented, with its interrupt, on the edge that accepts `msg_done`.
- R8: A byte that arrives while a completed block is waiting, or while the store is full, is discarded. `overflow` is then set from the next cycle and stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_valid | input | 1 | Deframer byte strobe |
| wr_data | input | 8 | Received byte |
| wr_eof | input | 1 | Byte is the last of a frame |
| rd_en | input | 1 | Host consumes the current byte |
| rd_data | output | 8 | Next unread byte of the presented block |
| thr_code | input | 2 | Threshold code (00:32, 01:16, 10:4, 11:2 bytes) |
| thr_load | input | 1 | Write `thr_code` into the shadow register |
| msg_done | input | 1 | Message-complete command, frees the presented block |
| blk_count | output | 7 | Valid bytes in the presented block, 0 when none |
| irq_full | output | 1 | Pool-full interrupt pulse |
| irq_end | output | 1 | Message-end interrupt pulse |
| overflow | output | 1 | Sticky lost-byte flag |

## Verification
The bench goes after several corner cases, and a wrong design shows up differently in each.
- A frame end on the very byte that fills a block: a design that raised both interrupts would misreport the block.
- A threshold written while a block is presented and unread: a design that applied it at once would let the following two bytes stay open instead of closing at the old size.
- A third block arriving behind a waiting one: if the byte were stored rather than dropped, the waiting block would come back with the wrong data.
- Stray reads past the end of a block, and a message-complete command with nothing presented: a design that honoured either would shift the next block's bytes or lose bytes already held.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  typedef enum logic [1:0] {
    THR_32 = 2'b00,
    THR_16 = 2'b01,
    THR_4  = 2'b10,
    THR_2  = 2'b11
  } thr_code_e;

  // Block size in bytes selected by a threshold code
  function automatic logic [6:0] thr_bytes(input logic [1:0] code);
    case (thr_code_e'(code))
      THR_32:  thr_bytes = 7'd32;
      THR_16:  thr_bytes = 7'd16;
      THR_4:   thr_bytes = 7'd4;
      default: thr_bytes = 7'd2;
    endcase
  endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rxbuf_thr.sv
module rxbuf_thr #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [1:0]    code_i,
  input  logic          apply_ok_i,
  output logic [CW-1:0] size_o
);
  import rxbuf_pkg::*;

  logic [1:0] shd_q, shd_d, act_q, act_d;
  logic       pend_q, pend_d;

  always_comb begin
    shd_d  = shd_q;
    pend_d = pend_q;
    act_d  = act_q;
    if (apply_ok_i && pend_q) begin
      act_d  = shd_q;
      pend_d = 1'b0;
    end
    if (load_i) begin
      shd_d  = code_i;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q  <= THR_32;
      act_q  <= THR_32;
      pend_q <= 1'b0;
    end else begin
      shd_q  <= shd_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  assign size_o = CW'(thr_bytes(act_q));

  // R6: outside a legal point the active threshold never moves
  p_thr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_ok_i |=> $stable(act_q));

endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid_i,
  input  logic          wr_eof_i,
  input  logic          rd_en_i,
  input  logic          msg_done_i,
  input  logic [CW-1:0] size_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic          apply_ok_o,
  output logic [CW-1:0] blk_count_o,
  output logic          irq_full_o,
  output logic          irq_end_o,
  output logic          overflow_o
);

  logic [AW-1:0] hd_q, hd_d, wp_q, wp_d;
  logic [CW-1:0] used_q, used_d, pend_q, pend_d, blk_q, blk_d, rdc_q, rdc_d;
  logic          pres_q, pres_d, wait_q, wait_d, weof_q, weof_d;
  logic          ifull_q, ifull_d, iend_q, iend_d, ovf_q, ovf_d;
  logic          full_c, acc, free, hold, rd_step, seg_done;
  logic [CW-1:0] seg_len;

  always_comb begin
    full_c   = wait_q || (used_q == CW'(DEPTH));
    acc      = wr_valid_i && !full_c;
    free     = msg_done_i && pres_q;
    hold     = pres_q && !free;
    rd_step  = pres_q && rd_en_i && (rdc_q < blk_q);
    seg_len  = pend_q + CW'(acc);
    seg_done = (seg_len != '0) && ((seg_len >= size_i) || (acc && wr_eof_i));

    hd_d    = free ? hd_q + blk_q[AW-1:0] : hd_q;
    wp_d    = acc ? wp_q + 1'b1 : wp_q;
    used_d  = used_q + CW'(acc) - (free ? blk_q : '0);
    ovf_d   = ovf_q || (wr_valid_i && full_c);
    pres_d  = hold;
    blk_d   = blk_q;
    rdc_d   = hold ? rdc_q + CW'(rd_step) : '0;
    pend_d  = seg_len;
    wait_d  = wait_q;
    weof_d  = weof_q;
    ifull_d = 1'b0;
    iend_d  = 1'b0;

    if (!hold) begin
      if (wait_q) begin
        // hand over the block that completed behind the freed one
        pres_d  = 1'b1;
        blk_d   = pend_q;
        pend_d  = '0;
        wait_d  = 1'b0;
        iend_d  = weof_q;
        ifull_d = !weof_q;
      end else if (seg_done) begin
        pres_d  = 1'b1;
        blk_d   = seg_len;
        pend_d  = '0;
        iend_d  = acc && wr_eof_i;
        ifull_d = !(acc && wr_eof_i);
      end
    end else if (!wait_q && seg_done) begin
      wait_d = 1'b1;
      weof_d = acc && wr_eof_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hd_q    <= '0;
      wp_q    <= '0;
      used_q  <= '0;
      pend_q  <= '0;
      blk_q   <= '0;
      rdc_q   <= '0;
      pres_q  <= 1'b0;
      wait_q  <= 1'b0;
      weof_q  <= 1'b0;
      ifull_q <= 1'b0;
      iend_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      hd_q    <= hd_d;
      wp_q    <= wp_d;
      used_q  <= used_d;
      pend_q  <= pend_d;
      blk_q   <= blk_d;
      rdc_q   <= rdc_d;
      pres_q  <= pres_d;
      wait_q  <= wait_d;
      weof_q  <= weof_d;
      ifull_q <= ifull_d;
      iend_q  <= iend_d;
      ovf_q   <= ovf_d;
    end
  end

  assign we_o        = acc;
  assign waddr_o     = wp_q;
  assign raddr_o     = hd_q + rdc_q[AW-1:0];
  assign apply_ok_o  = (!pres_q && used_q == '0) || (pres_q && rdc_q == blk_q);
  assign blk_count_o = pres_q ? blk_q : '0;
  assign irq_full_o  = ifull_q;
  assign irq_end_o   = iend_q;
  assign overflow_o  = ovf_q;

  // R3: a block is reported by exactly one kind of interrupt
  p_irq_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ifull_q && iend_q));
  // R2: a pool-full pulse always comes with a presented, non-empty block
  p_full_has_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ifull_q |-> (pres_q && blk_q != '0));
  // R4: the read cursor never runs past the presented block
  p_rd_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdc_q <= blk_q);
  // R7: a waiting block only exists behind a presented one
  p_wait_behind_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q |-> pres_q);
  // R7: occupancy stays within the store
  p_used_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= CW'(DEPTH));
  // R8: overflow is sticky
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

endmodule

// File: rtl/rx_block_buffer.sv
module rx_block_buffer #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,   // must hold two 32-byte blocks
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_eof,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    thr_code,
  input  logic          thr_load,
  input  logic          msg_done,
  output logic [CW-1:0] blk_count,
  output logic          irq_full,
  output logic          irq_end,
  output logic          overflow
);

  logic [1:0]    rs_q;
  logic          rst_i_n;
  logic          we, apply_ok;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] size;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  rxbuf_thr #(.CW(CW)) u_thr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .load_i     (thr_load),
    .code_i     (thr_code),
    .apply_ok_i (apply_ok),
    .size_o     (size)
  );

  rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .wr_valid_i  (wr_valid),
    .wr_eof_i    (wr_eof),
    .rd_en_i     (rd_en),
    .msg_done_i  (msg_done),
    .size_i      (size),
    .we_o        (we),
    .waddr_o     (waddr),
    .raddr_o     (raddr),
    .apply_ok_o  (apply_ok),
    .blk_count_o (blk_count),
    .irq_full_o  (irq_full),
    .irq_end_o   (irq_end),
    .overflow_o  (overflow)
  );

  rxbuf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rd_data)
  );

endmodule

// File: tb/test_rx_block_buffer.sv
`timescale 1ns/100ps
module test_rx_block_buffer;

  logic       clk = 1'b0;
  logic       rst_n, wr_valid, wr_eof, rd_en, thr_load, msg_done;
  logic [7:0] wr_data, rd_data;
  logic [1:0] thr_code;
  logic [6:0] blk_count;
  logic       irq_full, irq_end, overflow;
  int         errors = 0, checks = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  rx_block_buffer i_rx_block_buffer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_eof(wr_eof), .rd_en(rd_en), .rd_data(rd_data), .thr_code(thr_code),
    .thr_load(thr_load), .msg_done(msg_done), .blk_count(blk_count),
    .irq_full(irq_full), .irq_end(irq_end), .overflow(overflow)
  );

  typedef struct packed {
    logic [1:0] code;
    logic       eof;
    logic       exp_full;
    logic       exp_end;
    logic [6:0] n;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b0, 1'b1, 1'b0, 7'd32},  // R1/R2 default 32
    '{2'b01, 1'b0, 1'b1, 1'b0, 7'd16},  // R2
    '{2'b10, 1'b0, 1'b1, 1'b0, 7'd4},   // R2
    '{2'b11, 1'b0, 1'b1, 1'b0, 7'd2},   // R2
    '{2'b01, 1'b1, 1'b0, 1'b1, 7'd5},   // R3 short frame
    '{2'b10, 1'b1, 1'b0, 1'b1, 7'd4},   // R3 frame end on size
    '{2'b00, 1'b1, 1'b0, 1'b1, 7'd1}    // R3 single byte
  };

  function automatic logic [7:0] bv(int v, int i);
    return 8'(v * 37 + i * 5 + 3);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wr_byte(logic [7:0] b, logic eof);
    wr_valid = 1'b1; wr_data = b; wr_eof = eof;
    tick();
    wr_valid = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic rd_byte();
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
  endtask

  task automatic done_cmd();
    msg_done = 1'b1;
    tick();
    msg_done = 1'b0;
  endtask

  task automatic set_thr(logic [1:0] c);
    thr_code = c; thr_load = 1'b1;
    tick();
    thr_load = 1'b0;
    tick(); tick();
  endtask

  // read n bytes of stream v starting at index s, checking order (R4)
  task automatic read_blk(int v, int s, int n);
    for (int i = 0; i < n; i++) begin
      chk(rd_data == bv(v, s + i), "R4 read order", rd_data, bv(v, s + i));
      rd_byte();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_data = '0; wr_eof = 1'b0; rd_en = 1'b0;
    thr_code = 2'b00; thr_load = 1'b0; msg_done = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk(blk_count == 0, "R1 count", blk_count, 0);
    chk(!irq_full && !irq_end, "R1 irq", {irq_full, irq_end}, 0);
    chk(!overflow, "R1 overflow", overflow, 0);

    // table walk: R2 and R3
    for (int v = 0; v < NV; v++) begin
      bit early = 1'b0;
      if (v != 0) set_thr(TBL[v].code);
      for (int i = 0; i < int'(TBL[v].n); i++) begin
        wr_byte(bv(v, i), TBL[v].eof && (i == int'(TBL[v].n) - 1));
        if (i < int'(TBL[v].n) - 1 && (irq_full || irq_end)) early = 1'b1;
      end
      chk(!early, "R2 no early irq", early, 0);
      chk(irq_full == TBL[v].exp_full, "R2 irq_full", irq_full, TBL[v].exp_full);
      chk(irq_end == TBL[v].exp_end, "R3 irq_end", irq_end, TBL[v].exp_end);
      chk(blk_count == TBL[v].n, "R2/R3 count", blk_count, TBL[v].n);
      tick();
      chk(!irq_full && !irq_end, "R2 pulse width", {irq_full, irq_end}, 0);
      read_blk(v, 0, TBL[v].n);
      done_cmd();
      chk(blk_count == 0, "R5 freed", blk_count, 0);
    end
    chk(!overflow, "R8 no overflow yet", overflow, 0);

    // R7 and R8: waiting block and overflow, size 4
    set_thr(2'b10);
    for (int i = 0; i < 4; i++) wr_byte(bv(20, i), 1'b0);
    chk(irq_full && blk_count == 4, "R7 first block", blk_count, 4);
    begin
      bit any = 1'b0;
      for (int i = 4; i < 8; i++) begin
        wr_byte(bv(20, i), 1'b0);
        if (irq_full || irq_end) any = 1'b1;
      end
      chk(!any, "R7 waiting block silent", any, 0);
    end
    chk(blk_count == 4, "R7 count held", blk_count, 4);
    wr_byte(8'hEE, 1'b0);
    chk(overflow, "R8 overflow set", overflow, 1);
    read_blk(20, 0, 4);
    done_cmd();
    chk(irq_full && blk_count == 4, "R7 waiting block handed over", blk_count, 4);
    read_blk(20, 4, 4);
    done_cmd();
    chk(overflow, "R8 overflow sticky", overflow, 1);
    chk(blk_count == 0, "R5 freed", blk_count, 0);

    // R5: msg_done with no block presented is ignored
    wr_byte(bv(30, 0), 1'b0);
    done_cmd();
    chk(blk_count == 0 && !irq_full, "R5 ignored cmd", blk_count, 0);
    for (int i = 1; i < 4; i++) wr_byte(bv(30, i), 1'b0);
    chk(irq_full && blk_count == 4, "R5 bytes kept", blk_count, 4);
    read_blk(30, 0, 4);
    done_cmd();

    // R6: threshold held while block unread, R4 extra read ignored
    set_thr(2'b11);
    wr_byte(bv(40, 0), 1'b0);
    wr_byte(bv(40, 1), 1'b0);
    chk(irq_full && blk_count == 2, "R6 size 2 block", blk_count, 2);
    thr_code = 2'b01; thr_load = 1'b1;
    tick();
    thr_load = 1'b0;
    wr_byte(bv(40, 2), 1'b0);
    wr_byte(bv(40, 3), 1'b0);
    read_blk(40, 0, 2);
    rd_byte();  // R4 read past block end
    done_cmd();
    chk(irq_full && blk_count == 2, "R6 old size held", blk_count, 2);
    read_blk(40, 2, 2);
    done_cmd();
    begin
      bit any = 1'b0;
      for (int i = 0; i < 15; i++) begin
        wr_byte(bv(41, i), 1'b0);
        if (irq_full || irq_end) any = 1'b1;
      end
      chk(!any, "R6 new size not reached", any, 0);
    end
    wr_byte(bv(41, 15), 1'b0);
    chk(irq_full && blk_count == 16, "R6 new size applied", blk_count, 16);
    read_blk(41, 0, 16);
    done_cmd();

    // R8: only reset clears overflow
    rst_n = 1'b0;
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk(!overflow, "R8 cleared by reset", overflow, 0);
    chk(blk_count == 0, "R1 count after reset", blk_count, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule